// File: doc/BRIEF.md
# Command Issue and Interrupt Status Unit

This block sits between software registers and a command/data engine of a memory-card host. Software loads an argument and a command word; the command word carries a six-bit command index and a set of control flags (response wanted, long response, response CRC check, data phase, write direction, wait for the data path to go idle, stop/abort, initialization sequence, hold-register use) plus a start flag. The unit decides when the command may be handed over, emits a one-cycle start pulse with the decoded controls to the engine, and tracks the command until the engine reports that it was sent or answered.

Completion and error events from the engine accumulate in a sixteen-bit raw interrupt status register that software clears by writing ones. A mask register and a global interrupt enable in the control register reduce that status to one interrupt line. Responses from the engine are captured into four 32-bit response words, all four for a long response and only the first for a short one. The serial line protocol and CRC arithmetic live in the engine and reach this block only as event inputs.

Top module: `cmd_irq_unit`

## Requirements
- R1: After reset every register reads zero, `engStart` and `irq` are low. Byte addresses: control 0x00, argument 0x04, command 0x08, mask 0x0C, raw status 0x10, status 0x14 (bit 9 mirrors `dataBusy`), response words 0 to 3 at 0x18, 0x1C, 0x20, 0x24.
- R2: A command word written with bit 31 set is launched as a single-cycle `engStart` pulse, high in the second cycle after the write, carrying the argument and the decoded fields: index bits 5:0, response bit 6, long bit 7, CRC check bit 8, data bit 9, write bit 10, wait-previous bit 13, stop bit 14, init bit 15, hold bit 29.
- R3: Command register bit 31 reads 1 from the write until the command is handed to the engine and reads 0 from the cycle `engStart` is high.
- R4: While the pending command has bit 13 set and `dataBusy` is high, the command is held and bit 31 stays 1; a command without bit 13 launches regardless of `dataBusy`.
- R5: Raw status bit 2 (command done) is set when a launched command completes: on `engRespValid` if it expects a response, on `engCmdSent` if it does not; a response timeout event (bit 8) also completes a command that expects a response.
- R6: Each cycle, `engEvents` bit n sets raw status bit n for n in {1,3,4,5,6,7,8,9,11,13,15}; event bits 0, 2, 10, 12 and 14 are ignored.
- R7: Writing the raw status register clears every bit written as 1; an event setting a bit in the same cycle wins over the clear.
- R8: A response capture stores `engResp[32k+31:32k]` into response word k; a long response updates all four words, a short one updates word 0 only.
- R9: A command-register write while bit 31 is still 1 is ignored (pending fields unchanged) and sets raw status bit 12.
- R10: `irq` is high exactly when control bit 4 is set and some raw status bit is set whose mask bit is also set.
- R11: Control bits 4, 5 and 25 hold their written value; bits 0, 1 and 2 read 1 in the cycle after the write and 0 afterwards; writing bit 0 cancels a pending command (bit 31 clears, no launch follows).
- R12: Only one command is outstanding: a new command written after a launch stays pending (bit 31 = 1) until the previous one completes, then launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write byte address |
| wrData | input | 32 | Register write data |
| rdAddr | input | ADDR_W | Register read byte address |
| rdData | output | 32 | Register read data (combinational) |
| dataBusy | input | 1 | Data path busy from engine |
| engEvents | input | 16 | Event pulses, bit positions as raw status |
| engCmdSent | input | 1 | Engine finished sending the command |
| engRespValid | input | 1 | Engine delivers a response |
| engResp | input | 128 | Response payload, word k at bits 32k+31:32k |
| engStart | output | 1 | One-cycle command launch pulse |
| engIndex | output | 6 | Command index of launched command |
| engArg | output | 32 | Argument of launched command |
| engRespExp | output | 1 | Response expected |
| engRespLong | output | 1 | Long response |
| engCrcCheck | output | 1 | Check response CRC |
| engDataExp | output | 1 | Data phase expected |
| engWrite | output | 1 | Data direction is write |
| engWaitPrev | output | 1 | Wait for previous data |
| engStopAbort | output | 1 | Stop/abort command |
| engSendInit | output | 1 | Send initialization sequence first |
| engUseHold | output | 1 | Use hold register |
| irq | output | 1 | Masked, enabled interrupt |

## Verification
A stuck or wrongly cleared start flag shows within two cycles of a command write, either as a missing or extra `engStart` pulse or as bit 31 of the command register reading the wrong value. A lost outstanding flag shows as a second launch before the first command's completion, or as command done never being raised; both appear on the port on the completion cycle plus one. Corrupted raw status or mask state reaches `irq` and the status readback combinationally, so the very next read or interrupt sample exposes it.

// File: rtl/cmd_irq_pkg.sv
package cmd_irq_pkg;
  localparam int REG_W      = 32;
  localparam int STAT_W     = 16;
  localparam int IDX_W      = 6;
  localparam int RESP_WORDS = 4;
  localparam int RESP_W     = REG_W * RESP_WORDS;

  // command word bit positions (decoded by the engine and by software)
  localparam int CB_RESP  = 6;
  localparam int CB_LONG  = 7;
  localparam int CB_CRC   = 8;
  localparam int CB_DATA  = 9;
  localparam int CB_WRITE = 10;
  localparam int CB_WAIT  = 13;
  localparam int CB_STOP  = 14;
  localparam int CB_INIT  = 15;
  localparam int CB_HOLD  = 29;
  localparam int CB_START = 31;

  // raw status bits generated inside the block
  localparam int SB_DONE = 2;
  localparam int SB_RTO  = 8;
  localparam int SB_HLE  = 12;
  localparam logic [STAT_W-1:0] EVT_MASK = 16'hABFA;

  // control register
  localparam int CT_RST   = 0;
  localparam int CT_INTEN = 4;
  localparam logic [REG_W-1:0] CTRL_PULSE = 32'h0000_0007;
  localparam logic [REG_W-1:0] CTRL_KEEP  = 32'h0200_0030;

  localparam int ST_BUSY = 9;

  // byte addresses
  localparam int A_CTRL  = 'h00;
  localparam int A_ARG   = 'h04;
  localparam int A_CMD   = 'h08;
  localparam int A_MASK  = 'h0C;
  localparam int A_RAW   = 'h10;
  localparam int A_STAT  = 'h14;
  localparam int A_RESP0 = 'h18;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic respExp;
    logic respLong;
    logic crcCheck;
    logic dataExp;
    logic writeDir;
    logic waitPrev;
    logic stopAbort;
    logic sendInit;
    logic useHold;
  } cmdFields_t;

  typedef struct packed {
    logic accept;
    logic hle;
    logic launch;
    logic done;
    logic capture;
  } strobe_t;

  function automatic cmdFields_t cmdFromWord(input logic [REG_W-1:0] w);
    cmdFields_t f;
    f.idx       = w[IDX_W-1:0];
    f.respExp   = w[CB_RESP];
    f.respLong  = w[CB_LONG];
    f.crcCheck  = w[CB_CRC];
    f.dataExp   = w[CB_DATA];
    f.writeDir  = w[CB_WRITE];
    f.waitPrev  = w[CB_WAIT];
    f.stopAbort = w[CB_STOP];
    f.sendInit  = w[CB_INIT];
    f.useHold   = w[CB_HOLD];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] cmdToWord(input cmdFields_t f, input logic start);
    logic [REG_W-1:0] w;
    w = '0;
    w[IDX_W-1:0] = f.idx;
    w[CB_RESP]   = f.respExp;
    w[CB_LONG]   = f.respLong;
    w[CB_CRC]    = f.crcCheck;
    w[CB_DATA]   = f.dataExp;
    w[CB_WRITE]  = f.writeDir;
    w[CB_WAIT]   = f.waitPrev;
    w[CB_STOP]   = f.stopAbort;
    w[CB_INIT]   = f.sendInit;
    w[CB_HOLD]   = f.useHold;
    w[CB_START]  = start;
    return w;
  endfunction
endpackage

// File: rtl/cmd_irq_ctrl.sv
module cmd_irq_ctrl
  import cmd_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrStart,
  input  logic              wrCtrlRst,
  input  logic              dataBusy,
  input  logic              pendWaitPrev,
  input  logic              actRespExp,
  input  logic              respTimeout,
  input  logic              engCmdSent,
  input  logic              engRespValid,
  output strobe_t           stb,
  output logic              startBit,
  output logic              engStart
);
  logic outstanding;
  logic cmdWrite;
  logic ctrlWrite;
  logic abortNow;

  assign cmdWrite  = wrEn && (wrAddr == ADDR_W'(A_CMD));
  assign ctrlWrite = wrEn && (wrAddr == ADDR_W'(A_CTRL));
  assign abortNow  = ctrlWrite && wrCtrlRst;

  always_comb begin
    stb         = '0;
    stb.accept  = cmdWrite && !startBit;
    stb.hle     = cmdWrite && startBit;
    stb.launch  = startBit && !outstanding && !(pendWaitPrev && dataBusy) && !abortNow;
    stb.done    = outstanding &&
                  (actRespExp ? (engRespValid || respTimeout) : engCmdSent);
    stb.capture = outstanding && actRespExp && engRespValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit    <= 1'b0;
      outstanding <= 1'b0;
      engStart    <= 1'b0;
    end else begin
      engStart <= stb.launch;
      if (abortNow || stb.launch) startBit <= 1'b0;
      else if (stb.accept)        startBit <= wrStart;
      if (abortNow)               outstanding <= 1'b0;
      else if (stb.launch)        outstanding <= 1'b1;
      else if (stb.done)          outstanding <= 1'b0;
    end
  end

  // R3: the start flag is already clear when the engine sees the pulse
  assert_start_handoff_R3: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !startBit);
  // R12: a launch is never followed by another launch in the next cycle
  assert_single_flight_R12: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);
  // R9: a rejected write leaves the start flag set
  assert_locked_keeps_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hle && !abortNow && !stb.launch) |=> startBit);
endmodule

// File: rtl/cmd_irq_datapath.sv
module cmd_irq_datapath
  import cmd_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              startBit,
  input  logic              dataBusy,
  input  logic [STAT_W-1:0] engEvents,
  input  logic [RESP_W-1:0] engResp,
  output cmdFields_t        pendCmd,
  output cmdFields_t        actCmd,
  output logic [REG_W-1:0]  actArg,
  output logic              irq
);
  logic [REG_W-1:0]  ctrlQ;
  logic [REG_W-1:0]  argQ;
  logic [STAT_W-1:0] maskQ;
  logic [STAT_W-1:0] rawQ;
  logic [STAT_W-1:0] rawSet;
  logic [STAT_W-1:0] rawClr;
  logic [REG_W-1:0]  respQ [RESP_WORDS];
  logic ctrlWr, argWr, maskWr, rawWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(A_CTRL));
  assign argWr  = wrEn && (wrAddr == ADDR_W'(A_ARG));
  assign maskWr = wrEn && (wrAddr == ADDR_W'(A_MASK));
  assign rawWr  = wrEn && (wrAddr == ADDR_W'(A_RAW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      argQ    <= '0;
      maskQ   <= '0;
      pendCmd <= '0;
      actCmd  <= '0;
      actArg  <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= wrData & (CTRL_KEEP | CTRL_PULSE);
      else        ctrlQ <= ctrlQ & CTRL_KEEP;
      if (argWr)      argQ    <= wrData;
      if (maskWr)     maskQ   <= wrData[STAT_W-1:0];
      if (stb.accept) pendCmd <= cmdFromWord(wrData);
      if (stb.launch) begin
        actCmd <= pendCmd;
        actArg <= argQ;
      end
    end
  end

  // raw status: set wins over a same-cycle clear
  always_comb begin
    rawSet = (engEvents & EVT_MASK);
    rawSet[SB_DONE] = stb.done;
    rawSet[SB_HLE]  = stb.hle;
    rawClr = rawWr ? wrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= (rawQ & ~rawClr) | rawSet;
  end

  for (genvar k = 0; k < RESP_WORDS; k++) begin : g_resp
    logic load;
    if (k == 0) begin : g_first
      assign load = stb.capture;
    end else begin : g_rest
      assign load = stb.capture && actCmd.respLong;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     respQ[k] <= '0;
      else if (load) respQ[k] <= engResp[k*REG_W +: REG_W];
    end
  end

  assign irq = ctrlQ[CT_INTEN] && |(rawQ & maskQ);

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(A_CTRL)) rdData = ctrlQ;
    if (rdAddr == ADDR_W'(A_ARG))  rdData = argQ;
    if (rdAddr == ADDR_W'(A_CMD))  rdData = cmdToWord(pendCmd, startBit);
    if (rdAddr == ADDR_W'(A_MASK)) rdData = REG_W'(maskQ);
    if (rdAddr == ADDR_W'(A_RAW))  rdData = REG_W'(rawQ);
    if (rdAddr == ADDR_W'(A_STAT)) rdData[ST_BUSY] = dataBusy;
    for (int k = 0; k < RESP_WORDS; k++)
      if (rdAddr == ADDR_W'(A_RESP0 + 4*k)) rdData = respQ[k];
  end

  // R9: a rejected command write raises the hardware-locked bit
  assert_hle_raised_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.hle |=> rawQ[SB_HLE]);
  // R7: a write of one clears a status bit when no event sets it
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rawWr && wrData[3] && !engEvents[3]) |=> !rawQ[3]);
  // R8: a short response leaves the second response word untouched
  assert_short_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !actCmd.respLong) |=> $stable(respQ[1]));
  // R11: reset request bits fall back to zero without a new write
  assert_rst_selfclear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CT_RST] && !ctrlWr) |=> !ctrlQ[CT_RST]);
  // R5: command done only appears alongside a completion strobe
  assert_done_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rawQ[SB_DONE])) |-> $past(stb.done));
endmodule

// File: rtl/cmd_irq_unit.sv
module cmd_irq_unit
  import cmd_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              dataBusy,
  input  logic [15:0]       engEvents,
  input  logic              engCmdSent,
  input  logic              engRespValid,
  input  logic [127:0]      engResp,
  output logic              engStart,
  output logic [5:0]        engIndex,
  output logic [31:0]       engArg,
  output logic              engRespExp,
  output logic              engRespLong,
  output logic              engCrcCheck,
  output logic              engDataExp,
  output logic              engWrite,
  output logic              engWaitPrev,
  output logic              engStopAbort,
  output logic              engSendInit,
  output logic              engUseHold,
  output logic              irq
);
  strobe_t    stb;
  logic       startBit;
  cmdFields_t pendCmd;
  cmdFields_t actCmd;

  cmd_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrStart(wrData[CB_START]), .wrCtrlRst(wrData[CT_RST]),
    .dataBusy(dataBusy), .pendWaitPrev(pendCmd.waitPrev),
    .actRespExp(actCmd.respExp), .respTimeout(engEvents[SB_RTO]),
    .engCmdSent(engCmdSent), .engRespValid(engRespValid),
    .stb(stb), .startBit(startBit), .engStart(engStart)
  );

  cmd_irq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .startBit(startBit), .dataBusy(dataBusy), .engEvents(engEvents),
    .engResp(engResp), .pendCmd(pendCmd), .actCmd(actCmd),
    .actArg(engArg), .irq(irq)
  );

  assign engIndex     = actCmd.idx;
  assign engRespExp   = actCmd.respExp;
  assign engRespLong  = actCmd.respLong;
  assign engCrcCheck  = actCmd.crcCheck;
  assign engDataExp   = actCmd.dataExp;
  assign engWrite     = actCmd.writeDir;
  assign engWaitPrev  = actCmd.waitPrev;
  assign engStopAbort = actCmd.stopAbort;
  assign engSendInit  = actCmd.sendInit;
  assign engUseHold   = actCmd.useHold;

  // R4: a command that waits for the data path never launches over a busy one
  assert_wait_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engWaitPrev) |-> $past(!dataBusy));
endmodule

// File: tb/cmd_irq_unit_bench.sv
`timescale 1ns/1ps
module cmd_irq_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic [31:0] rdData;
  logic dataBusy = 1'b0;
  logic [15:0] engEvents = '0;
  logic engCmdSent = 1'b0;
  logic engRespValid = 1'b0;
  logic [127:0] engResp = '0;
  logic engStart;
  logic [5:0] engIndex;
  logic [31:0] engArg;
  logic engRespExp, engRespLong, engCrcCheck, engDataExp, engWrite;
  logic engWaitPrev, engStopAbort, engSendInit, engUseHold, irq;

  int checks = 0;
  int errors = 0;
  int popCount = 0;
  logic [46:0] expQ[$];

  always #4 clk = ~clk;

  cmd_irq_unit u_cmd_irq_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dataBusy(dataBusy), .engEvents(engEvents),
    .engCmdSent(engCmdSent), .engRespValid(engRespValid), .engResp(engResp),
    .engStart(engStart), .engIndex(engIndex), .engArg(engArg),
    .engRespExp(engRespExp), .engRespLong(engRespLong), .engCrcCheck(engCrcCheck),
    .engDataExp(engDataExp), .engWrite(engWrite), .engWaitPrev(engWaitPrev),
    .engStopAbort(engStopAbort), .engSendInit(engSendInit), .engUseHold(engUseHold),
    .irq(irq)
  );

  // flag order: [8]resp [7]long [6]crc [5]data [4]write [3]wait [2]stop [1]init [0]hold
  localparam logic [8:0] F_RESP = 9'h100, F_LONG = 9'h080, F_CRC = 9'h040,
                         F_DATA = 9'h020, F_WR = 9'h010, F_WAIT = 9'h008,
                         F_STOP = 9'h004, F_INIT = 9'h002, F_HOLD = 9'h001;

  function automatic logic [31:0] mkCmd(input logic [5:0] idx, input logic [8:0] f);
    logic [31:0] w;
    w = {26'd0, idx};
    w[6] = f[8]; w[7] = f[7]; w[8] = f[6]; w[9] = f[5]; w[10] = f[4];
    w[13] = f[3]; w[14] = f[2]; w[15] = f[1]; w[29] = f[0]; w[31] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readChk(input string req, input logic [7:0] a, input logic [31:0] m,
                         input logic [31:0] exp);
    rdAddr = a;
    #1;
    chk(req, rdData & m, exp);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: push the expected launch, then program the unit
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [8:0] f);
    writeReg(8'h04, arg);
    expQ.push_back({idx, arg, f});
    writeReg(8'h08, mkCmd(idx, f));
  endtask

  task automatic pulseSent();
    engCmdSent = 1'b1; @(negedge clk); engCmdSent = 1'b0;
  endtask

  task automatic pulseResp(input logic [127:0] r);
    engResp = r; engRespValid = 1'b1; @(negedge clk); engRespValid = 1'b0;
  endtask

  task automatic pulseEvt(input logic [15:0] e);
    engEvents = e; @(negedge clk); engEvents = '0;
  endtask

  task automatic chkPop(input string req, input int exp);
    #1;
    chk(req, popCount, exp);
  endtask

  // monitor: compare every launch with the scoreboard head (R2)
  always @(negedge clk) begin
    if (rstN && engStart === 1'b1) begin
      logic [46:0] got;
      logic [46:0] want;
      got = {engIndex, engArg, engRespExp, engRespLong, engCrcCheck, engDataExp,
             engWrite, engWaitPrev, engStopAbort, engSendInit, engUseHold};
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 launch: actual 0x%012h expected no launch", got);
      end else begin
        want = expQ.pop_front();
        if (got !== want) begin
          errors++;
          $display("FAIL R2 launch: actual 0x%012h expected 0x%012h", got, want);
        end
      end
      popCount++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readChk("R1 ctrl", 8'h00, 32'hFFFF_FFFF, 32'h0);
    readChk("R1 cmd", 8'h08, 32'hFFFF_FFFF, 32'h0);
    readChk("R1 raw", 8'h10, 32'hFFFF_FFFF, 32'h0);
    readChk("R1 resp0", 8'h18, 32'hFFFF_FFFF, 32'h0);
    chk("R1 engStart", {31'd0, engStart}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 R3 R5 R7: no-response command
    issue(6'd0, 32'h0, F_INIT | F_HOLD);
    readChk("R3 start set", 8'h08, 32'h8000_0000, 32'h8000_0000);
    @(negedge clk);
    readChk("R3 start cleared", 8'h08, 32'h8000_0000, 32'h0);
    chkPop("R2 launch count", 1);
    pulseSent();
    readChk("R5 done on sent", 8'h10, 32'hFFFF, 32'h0004);
    writeReg(8'h10, 32'h0004);
    readChk("R7 w1c", 8'h10, 32'hFFFF, 32'h0);

    // R4 hold while busy, R9 locked write, R8 short response
    dataBusy = 1'b1;
    issue(6'd17, 32'h0000_1234, F_RESP | F_CRC | F_DATA | F_WAIT);
    repeat (4) @(negedge clk);
    readChk("R4 held start", 8'h08, 32'h8000_0000, 32'h8000_0000);
    chkPop("R4 no launch while busy", 1);
    readChk("R1 status busy bit", 8'h14, 32'hFFFF_FFFF, 32'h0000_0200);
    writeReg(8'h08, mkCmd(6'd40, F_STOP));
    readChk("R9 hle bit", 8'h10, 32'hFFFF, 32'h1000);
    readChk("R9 index kept", 8'h08, 32'h3F, 32'd17);
    dataBusy = 1'b0;
    @(negedge clk);
    chkPop("R4 launch after idle", 2);
    pulseResp({32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'hA5A5_0017});
    readChk("R8 short word0", 8'h18, 32'hFFFF_FFFF, 32'hA5A5_0017);
    readChk("R8 short word1 kept", 8'h1C, 32'hFFFF_FFFF, 32'h0);
    readChk("R5 done on response", 8'h10, 32'hFFFF, 32'h1004);
    writeReg(8'h10, 32'hFFFF_FFFF);
    readChk("R7 clear all", 8'h10, 32'hFFFF, 32'h0);

    // R8 long response
    issue(6'd2, 32'h0, F_RESP | F_LONG | F_CRC);
    @(negedge clk);
    chkPop("R2 long launch", 3);
    pulseResp({32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
    readChk("R8 long word0", 8'h18, 32'hFFFF_FFFF, 32'h1111_1111);
    readChk("R8 long word1", 8'h1C, 32'hFFFF_FFFF, 32'h2222_2222);
    readChk("R8 long word2", 8'h20, 32'hFFFF_FFFF, 32'h3333_3333);
    readChk("R8 long word3", 8'h24, 32'hFFFF_FFFF, 32'h4444_4444);

    // R8 short after long keeps upper words
    issue(6'd13, 32'h0000_0001, F_RESP | F_CRC | F_WAIT);
    @(negedge clk);
    chkPop("R4 wait flag idle launch", 4);
    pulseResp({96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hCAFE_0013});
    readChk("R8 short word0", 8'h18, 32'hFFFF_FFFF, 32'hCAFE_0013);
    readChk("R8 short word3 kept", 8'h24, 32'hFFFF_FFFF, 32'h4444_4444);

    // R4 no wait flag launches while busy; R5 timeout completes
    writeReg(8'h10, 32'hFFFF);
    dataBusy = 1'b1;
    issue(6'd18, 32'h0000_0800, F_RESP | F_CRC | F_DATA);
    @(negedge clk);
    chkPop("R4 launch despite busy", 5);
    pulseEvt(16'h0100);
    readChk("R5 timeout completes", 8'h10, 32'hFFFF, 32'h0104);
    dataBusy = 1'b0;

    // R12 single outstanding command
    writeReg(8'h10, 32'hFFFF);
    issue(6'd5, 32'h0, 9'h000);
    @(negedge clk);
    chkPop("R12 first launch", 6);
    issue(6'd6, 32'h0000_0007, F_HOLD);
    repeat (3) @(negedge clk);
    readChk("R12 second pending", 8'h08, 32'h8000_0000, 32'h8000_0000);
    chkPop("R12 no second launch", 6);
    pulseSent();
    @(negedge clk);
    chkPop("R12 second launch", 7);
    pulseSent();

    // R6 event map, R10 interrupt gating
    writeReg(8'h10, 32'hFFFF);
    pulseEvt(16'hFFFF);
    readChk("R6 event map", 8'h10, 32'hFFFF, 32'hABFA);
    writeReg(8'h0C, 32'h0008);
    chk("R10 disabled", {31'd0, irq}, 32'h0);
    writeReg(8'h00, 32'h0000_0010);
    chk("R10 enabled", {31'd0, irq}, 32'h1);
    writeReg(8'h0C, 32'h0004);
    chk("R10 masked out", {31'd0, irq}, 32'h0);
    writeReg(8'h0C, 32'h8000);
    chk("R10 bit15", {31'd0, irq}, 32'h1);
    writeReg(8'h00, 32'h0);
    chk("R10 disabled again", {31'd0, irq}, 32'h0);

    // R7 set wins over clear
    writeReg(8'h10, 32'hFFFF);
    engEvents = 16'h0008;
    writeReg(8'h10, 32'h0008);
    engEvents = '0;
    readChk("R7 set wins", 8'h10, 32'hFFFF, 32'h0008);
    writeReg(8'h10, 32'h0008);
    readChk("R7 cleared", 8'h10, 32'hFFFF, 32'h0);

    // R11 control self-clear and abort
    dataBusy = 1'b1;
    writeReg(8'h08, mkCmd(6'd24, F_WAIT | F_WR | F_DATA));
    readChk("R11 pending", 8'h08, 32'h8000_0000, 32'h8000_0000);
    writeReg(8'h00, 32'h0200_0037);
    readChk("R11 ctrl first cycle", 8'h00, 32'hFFFF_FFFF, 32'h0200_0037);
    readChk("R11 abort clears start", 8'h08, 32'h8000_0000, 32'h0);
    @(negedge clk);
    readChk("R11 ctrl self clear", 8'h00, 32'hFFFF_FFFF, 32'h0200_0030);
    dataBusy = 1'b0;
    repeat (3) @(negedge clk);
    chkPop("R11 no launch after abort", 7);
    chk("R2 scoreboard drained", expQ.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule